// File: doc/BRIEF.md
# Flash self-programming command controller

This block accepts store-program-memory requests from a processor and turns them into page-buffer loads, page erases and page writes on a small flash array model. The array is divided by page number into a lower region that may be read while another page is being programmed and an upper region that may not. Software first writes a command code into an 8-bit control/status register. It then has a short window in which to issue the strobe, together with a word address and a data operand.

Erase and write operations run for a number of cycles set by parameters. While one runs, the lower region is marked busy and reads of it return a fixed pattern. The busy mark stays set after the operation finishes, until software writes the re-enable code. When the target page is in the upper region, the processor is halted for the length of the operation. An interrupt line stays asserted whenever interrupts are enabled and no command is armed or running.

Top module: `fsp_ctrl`

## Requirements
- R1: After reset the status read-back is 0x00, `rww_busy`, `cpu_halt`, `spm_irq` and `rd_err` are low, every array word reads all ones, and every page-buffer word is all ones.
- R2: A write of a command code arms it. The low seven bits select the command: 0x01 buffer load, 0x03 page erase, 0x05 page write. A strobe is accepted on any of the four clock edges that follow the write. If no strobe arrives on the fourth of those edges, the command is dropped and bit 0 of the status falls on that edge.
- R3: An accepted load stores the data operand into the buffer word given by the low address bits, and the command ends on the same edge. A second load to a buffer word that is already loaded has no effect until the buffer is erased.
- R4: An accepted erase sets every word of the page named by the upper address bits to all ones. The change becomes visible ERASE_CYCLES edges after the strobe edge. The word bits of the address and the data operand are ignored.
- R5: An accepted page write copies the whole buffer into the addressed page WRITE_CYCLES edges after the strobe edge, with unloaded words written as all ones. It then erases the buffer. The data operand and the word bits of the address are ignored.
- R6: `rww_busy` rises on the strobe edge of any erase or write and stays high after the operation completes. It clears only on a write of re-enable code 0x11 (bit 7 is don't-care) while no operation runs, and that write also erases the buffer.
- R7: `cpu_halt` is high from the strobe edge until the completion edge when the target page is at or above NRWW_FIRST, and stays low when the target is below it.
- R8: While `rww_busy` is high, a read of a page below NRWW_FIRST returns BLOCK_VAL (0x5A5A by default), and a read with `rd_en` sets the sticky `rd_err`. Reads of the upper pages always return array data.
- R9: `spm_irq` equals the stored interrupt-enable bit (bit 7 of the last register write) while bit 0 of the status is low, and is low otherwise.
- R10: Register writes while an operation runs change only the interrupt-enable bit. Strobes while nothing is armed, strobes during an operation, and writes of any other code have no effect.
- R11: The status read-back has bit 0 = command armed or running, bit 6 = `rww_busy`, bit 7 = interrupt enable, and all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_we | input | 1 | Control register write strobe |
| csr_wdata | input | 8 | Control register write data |
| csr_rdata | output | 8 | Status read-back |
| spm_strobe | input | 1 | Store-program-memory execute strobe |
| spm_addr | input | ADDR_W (5) | Word address: page in the upper bits, word in the lower bits |
| spm_data | input | DATA_W (16) | Data operand for buffer loads |
| rd_en | input | 1 | Processor read of the flash array |
| rd_addr | input | ADDR_W (5) | Read word address |
| rd_data | output | DATA_W (16) | Read data, combinational |
| rww_busy | output | 1 | Lower region blocked for reading |
| cpu_halt | output | 1 | Processor halt request |
| spm_irq | output | 1 | Ready interrupt, level |
| rd_err | output | 1 | Sticky flag for blocked reads |

## Verification
Loads, arming, dropped commands, `rww_busy` and `cpu_halt` all change on the strobe or register-write edge itself. Erase and write results and the end of the halt appear exactly ERASE_CYCLES or WRITE_CYCLES edges after the strobe edge. `rd_data` and `spm_irq` follow their inputs within the same cycle. The bench drives inputs 2 ns after a rising edge, so a reference model that updates on that edge sees them settled. It compares every output at the following falling edge. The directed checks wait the exact edge counts above, including strobes on the fourth and fifth edge after arming.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_ERASE = 2'd2,
      OP_WRITE = 2'd3
   } fsp_op_e;

   localparam logic [6:0] CODE_LOAD  = 7'h01;
   localparam logic [6:0] CODE_ERASE = 7'h03;
   localparam logic [6:0] CODE_WRITE = 7'h05;
   localparam logic [6:0] CODE_REEN  = 7'h11;

   localparam int unsigned ST_ACTIVE = 0;
   localparam int unsigned ST_BUSY   = 6;
   localparam int unsigned ST_IRQEN  = 7;

   function automatic fsp_op_e decode_cmd(input logic [6:0] code);
      case (code)
         CODE_LOAD:  return OP_LOAD;
         CODE_ERASE: return OP_ERASE;
         CODE_WRITE: return OP_WRITE;
         default:    return OP_NONE;
      endcase
   endfunction

endpackage

// File: rtl/fsp_arm.sv
module fsp_arm
   import fsp_pkg::*;
#(
   parameter int unsigned WINDOW = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       csr_we,
   input  logic [7:0] csr_wdata,
   input  logic       strobe,
   input  logic       op_running,
   input  logic       op_done,
   output logic       active,
   output logic       irq_en,
   output logic       fire_load,
   output logic       fire_op,
   output logic       fire_is_write,
   output logic       reen
);
   localparam int unsigned WIN_W = $clog2(WINDOW + 1);

   fsp_op_e          cmd_q;
   fsp_op_e          cmd_dec;
   logic [WIN_W-1:0] win_q;
   logic             take;
   logic             fire;

   assign cmd_dec       = decode_cmd(csr_wdata[6:0]);
   assign take          = csr_we && !op_running;
   assign reen          = take && (csr_wdata[6:0] == CODE_REEN);
   assign fire          = active && !op_running && strobe && !csr_we;
   assign fire_load     = fire && (cmd_q == OP_LOAD);
   assign fire_op       = fire && (cmd_q == OP_ERASE || cmd_q == OP_WRITE);
   assign fire_is_write = (cmd_q == OP_WRITE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         win_q  <= '0;
         cmd_q  <= OP_NONE;
         irq_en <= 1'b0;
      end else begin
         if (csr_we) irq_en <= csr_wdata[7];
         if (take && cmd_dec != OP_NONE) begin
            active <= 1'b1;
            win_q  <= WIN_W'(WINDOW);
            cmd_q  <= cmd_dec;
         end else if (fire_load || op_done) begin
            active <= 1'b0;
         end else if (active && !op_running && !fire_op) begin
            if (win_q == WIN_W'(1)) active <= 1'b0;
            else                    win_q  <= win_q - 1'b1;
         end
      end
   end

   initial begin
      assert (WINDOW >= 1) else $error("fsp_arm: WINDOW must be at least 1");
   end

   p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !op_running) |-> (win_q >= WIN_W'(1) && win_q <= WIN_W'(WINDOW)));

   p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      op_running |=> $stable(cmd_q));

endmodule

// File: rtl/fsp_page_buf.sv
module fsp_page_buf #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned PAGE_WORDS = 4,
   localparam int unsigned WORD_W    = $clog2(PAGE_WORDS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ld_en,
   input  logic [WORD_W-1:0]            ld_word,
   input  logic [DATA_W-1:0]            ld_data,
   input  logic                         clr,
   output logic [PAGE_WORDS*DATA_W-1:0] words
);

   for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_word
      logic [DATA_W-1:0] data_q;
      logic              loaded_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_q   <= '1;
            loaded_q <= 1'b0;
         end else if (clr) begin
            data_q   <= '1;
            loaded_q <= 1'b0;
         end else if (ld_en && ld_word == WORD_W'(i) && !loaded_q) begin
            data_q   <= ld_data;
            loaded_q <= 1'b1;
         end
      end

      assign words[i*DATA_W +: DATA_W] = data_q;

      p_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (ld_en && ld_word == WORD_W'(i) && loaded_q && !clr) |=> $stable(data_q));
   end

   p_clr_ld_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr && ld_en));

endmodule

// File: rtl/fsp_flash_model.sv
module fsp_flash_model #(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned PAGE_WORDS   = 4,
   parameter int unsigned NUM_PAGES    = 8,
   parameter int unsigned ERASE_CYCLES = 6,
   parameter int unsigned WRITE_CYCLES = 9,
   localparam int unsigned WORD_W      = $clog2(PAGE_WORDS),
   localparam int unsigned PAGE_W      = $clog2(NUM_PAGES),
   localparam int unsigned ADDR_W      = PAGE_W + WORD_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         start_write,
   input  logic [PAGE_W-1:0]            start_page,
   input  logic [PAGE_WORDS*DATA_W-1:0] buf_words,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [DATA_W-1:0]            rd_word,
   output logic                         busy,
   output logic                         done,
   output logic [PAGE_W-1:0]            op_page
);
   localparam int unsigned MAX_CYC = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES;
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
   localparam int unsigned DEPTH   = NUM_PAGES * PAGE_WORDS;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic              write_q;

   assign done    = busy && (cnt_q == CNT_W'(1));
   assign rd_word = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cnt_q   <= '0;
         write_q <= 1'b0;
         op_page <= '0;
         for (int a = 0; a < DEPTH; a++) mem[a] <= '1;
      end else if (start) begin
         busy    <= 1'b1;
         cnt_q   <= start_write ? CNT_W'(WRITE_CYCLES) : CNT_W'(ERASE_CYCLES);
         write_q <= start_write;
         op_page <= start_page;
      end else if (done) begin
         busy <= 1'b0;
         for (int w = 0; w < PAGE_WORDS; w++) begin
            mem[{op_page, WORD_W'(w)}] <= write_q ? buf_words[w*DATA_W +: DATA_W] : '1;
         end
      end else if (busy) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   initial begin
      assert (ERASE_CYCLES >= 1 && WRITE_CYCLES >= 1)
         else $error("fsp_flash_model: operation lengths must be at least 1");
      assert ((1 << WORD_W) == PAGE_WORDS && (1 << PAGE_W) == NUM_PAGES)
         else $error("fsp_flash_model: page size and page count must be powers of two");
   end

   p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

   p_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt_q > CNT_W'(1)) |=> busy);

endmodule

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
   import fsp_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned PAGE_WORDS   = 4,
   parameter int unsigned NUM_PAGES    = 8,
   parameter int unsigned NRWW_FIRST   = 6,
   parameter int unsigned ERASE_CYCLES = 6,
   parameter int unsigned WRITE_CYCLES = 9,
   parameter int unsigned WINDOW       = 4,
   parameter logic [DATA_W-1:0] BLOCK_VAL = DATA_W'(16'h5A5A),
   localparam int unsigned WORD_W      = $clog2(PAGE_WORDS),
   localparam int unsigned PAGE_W      = $clog2(NUM_PAGES),
   localparam int unsigned ADDR_W      = PAGE_W + WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic [7:0]        csr_wdata,
   output logic [7:0]        csr_rdata,
   input  logic              spm_strobe,
   input  logic [ADDR_W-1:0] spm_addr,
   input  logic [DATA_W-1:0] spm_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rww_busy,
   output logic              cpu_halt,
   output logic              spm_irq,
   output logic              rd_err
);
   localparam logic [PAGE_W-1:0] NRWW_PG = PAGE_W'(NRWW_FIRST);

   logic                         active, irq_en;
   logic                         fire_load, fire_op, fire_is_write, reen;
   logic                         op_busy, op_done;
   logic [PAGE_W-1:0]            op_page;
   logic [PAGE_WORDS*DATA_W-1:0] buf_words;
   logic [DATA_W-1:0]            mem_word;
   logic                         rd_blocked;

   fsp_arm #(.WINDOW(WINDOW)) u_arm (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
      .strobe(spm_strobe), .op_running(op_busy), .op_done(op_done),
      .active(active), .irq_en(irq_en), .fire_load(fire_load), .fire_op(fire_op),
      .fire_is_write(fire_is_write), .reen(reen)
   );

   fsp_page_buf #(.DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS)) u_buf (
      .clk(clk), .rst_n(rst_n), .ld_en(fire_load), .ld_word(spm_addr[WORD_W-1:0]),
      .ld_data(spm_data), .clr(reen || (op_done && fire_is_write)), .words(buf_words)
   );

   fsp_flash_model #(
      .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES),
      .ERASE_CYCLES(ERASE_CYCLES), .WRITE_CYCLES(WRITE_CYCLES)
   ) u_flash (
      .clk(clk), .rst_n(rst_n), .start(fire_op), .start_write(fire_is_write),
      .start_page(spm_addr[ADDR_W-1:WORD_W]), .buf_words(buf_words),
      .rd_addr(rd_addr), .rd_word(mem_word), .busy(op_busy), .done(op_done),
      .op_page(op_page)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rww_busy <= 1'b0;
      else if (reen)    rww_busy <= 1'b0;
      else if (fire_op) rww_busy <= 1'b1;
   end

   assign rd_blocked = rww_busy && (rd_addr[ADDR_W-1:WORD_W] < NRWW_PG);
   assign rd_data    = rd_blocked ? BLOCK_VAL : mem_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    rd_err <= 1'b0;
      else if (rd_en && rd_blocked)  rd_err <= 1'b1;
   end

   assign cpu_halt = op_busy && (op_page >= NRWW_PG);
   assign spm_irq  = irq_en && !active;

   always_comb begin
      csr_rdata            = '0;
      csr_rdata[ST_ACTIVE] = active;
      csr_rdata[ST_BUSY]   = rww_busy;
      csr_rdata[ST_IRQEN]  = irq_en;
   end

   initial begin
      assert (NRWW_FIRST < NUM_PAGES) else $error("fsp_ctrl: NRWW_FIRST out of range");
   end

   p_halt_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_halt |-> rww_busy);

   p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rww_busy && !(csr_we && csr_wdata[6:0] == CODE_REEN)) |=> rww_busy);

   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |=> rd_err);

   p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      spm_irq |-> !op_busy);

endmodule

// File: tb/fsp_ctrl_tb.sv
`timescale 1ns/1ps
module fsp_ctrl_tb;
   localparam int PW = 4, NP = 8, NRWW = 6, ECYC = 6, WCYC = 9, DEPTH = PW * NP;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [7:0]  csr_wdata = '0;
   logic [7:0]  csr_rdata;
   logic        spm_strobe = 1'b0;
   logic [4:0]  spm_addr = '0;
   logic [15:0] spm_data = '0;
   logic        rd_en = 1'b0;
   logic [4:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        rww_busy, cpu_halt, spm_irq, rd_err;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   fsp_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .spm_strobe(spm_strobe), .spm_addr(spm_addr), .spm_data(spm_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .rww_busy(rww_busy), .cpu_halt(cpu_halt), .spm_irq(spm_irq), .rd_err(rd_err)
   );

   // ---------------- reference model ----------------
   int m_active, m_win, m_cmd, m_run, m_cnt, m_wr, m_page, m_busy, m_irqen, m_err;
   int m_mem [DEPTH];
   int m_buf [PW];
   int m_flag [PW];
   bit started = 0;

   task automatic m_reset();
      m_active = 0; m_win = 0; m_cmd = 0; m_run = 0; m_cnt = 0; m_wr = 0;
      m_page = 0; m_busy = 0; m_irqen = 0; m_err = 0;
      for (int a = 0; a < DEPTH; a++) m_mem[a] = 16'hFFFF;
      for (int w = 0; w < PW; w++) begin m_buf[w] = 16'hFFFF; m_flag[w] = 0; end
   endtask

   initial m_reset();

   always @(posedge clk) begin
      int act0, run0, win0, busy0, code;
      started = 1;
      if (!rst_n) m_reset();
      else begin
         act0 = m_active; run0 = m_run; win0 = m_win; busy0 = m_busy;
         if (rd_en && (rd_addr / PW) < NRWW && busy0) m_err = 1;
         if (run0) begin
            if (m_cnt == 1) begin
               for (int w = 0; w < PW; w++)
                  m_mem[m_page * PW + w] = m_wr ? m_buf[w] : 16'hFFFF;
               if (m_wr) for (int w = 0; w < PW; w++) begin m_buf[w] = 16'hFFFF; m_flag[w] = 0; end
               m_run = 0; m_active = 0;
            end else m_cnt--;
         end
         if (csr_we) begin
            m_irqen = csr_wdata[7];
            code = csr_wdata[6:0];
            if (!run0) begin
               if (code == 1 || code == 3 || code == 5) begin
                  m_active = 1; m_win = 4; m_cmd = code;
               end else if (code == 'h11) begin
                  m_busy = 0;
                  for (int w = 0; w < PW; w++) begin m_buf[w] = 16'hFFFF; m_flag[w] = 0; end
               end
            end
         end else if (spm_strobe && act0 && !run0) begin
            if (m_cmd == 1) begin
               if (!m_flag[spm_addr % PW]) begin
                  m_buf[spm_addr % PW] = spm_data; m_flag[spm_addr % PW] = 1;
               end
               m_active = 0;
            end else begin
               m_run = 1; m_wr = (m_cmd == 5); m_cnt = m_wr ? WCYC : ECYC;
               m_page = spm_addr / PW; m_busy = 1;
            end
         end else if (act0 && !run0) begin
            if (win0 == 1) m_active = 0; else m_win--;
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every clock, half a period after the edge
   always @(negedge clk) begin
      int e_rd;
      if (started && !finished) begin
         e_rd = (m_busy && (rd_addr / PW) < NRWW) ? 16'h5A5A : m_mem[rd_addr];
         chk("R11 csr_rdata", csr_rdata, (m_irqen << 7) | (m_busy << 6) | m_active);
         chk("R6 rww_busy", rww_busy, m_busy);
         chk("R7 cpu_halt", cpu_halt, (m_run && m_page >= NRWW) ? 1 : 0);
         chk("R9 spm_irq", spm_irq, (m_irqen && !m_active) ? 1 : 0);
         chk("R8 rd_err", rd_err, m_err);
         chk("R8 rd_data", rd_data, e_rd);
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [4:0] ad(int page, int word);
      return 5'(page * PW + word);
   endfunction

   task automatic csr_wr(logic [7:0] v);
      @(posedge clk); #2; csr_we = 1; csr_wdata = v;
      @(posedge clk); #2; csr_we = 0;
   endtask

   task automatic strobe(logic [4:0] a, logic [15:0] d);
      @(posedge clk); #2; spm_strobe = 1; spm_addr = a; spm_data = d;
      @(posedge clk); #2; spm_strobe = 0;
   endtask

   // strobe sampled 'gap' edges after the register write edge
   task automatic cmd(logic [7:0] v, int gap, logic [4:0] a, logic [15:0] d);
      @(posedge clk); #2; csr_we = 1; csr_wdata = v;
      @(posedge clk); #2; csr_we = 0;
      if (gap > 1) begin repeat (gap - 1) @(posedge clk); #2; end
      spm_strobe = 1; spm_addr = a; spm_data = d;
      @(posedge clk); #2; spm_strobe = 0;
   endtask

   task automatic rd_chk(logic [4:0] a, int exp, string tag);
      @(posedge clk); #2; rd_en = 1; rd_addr = a;
      @(negedge clk); chk(tag, rd_data, exp);
      @(posedge clk); #2; rd_en = 0;
   endtask

   task automatic wait_edges(int n);
      repeat (n) @(posedge clk); #2;
   endtask

   task automatic summary();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         summary();
      end
   end

   initial begin
      repeat (3) @(posedge clk); #2; rst_n = 1;
      @(negedge clk);
      chk("R1 status", csr_rdata, 0); chk("R1 busy", rww_busy, 0);
      chk("R1 halt", cpu_halt, 0); chk("R1 irq", spm_irq, 0); chk("R1 err", rd_err, 0);
      rd_chk(ad(7, 0), 16'hFFFF, "R1 array");

      csr_wr(8'h80);
      @(negedge clk); chk("R9 irq on", spm_irq, 1); chk("R11 irqen bit", csr_rdata, 8'h80);

      cmd(8'h81, 1, ad(7, 0), 16'h1234);
      @(negedge clk); chk("R3 load ends", csr_rdata, 8'h80);
      cmd(8'h81, 1, ad(7, 1), 16'h5678);
      cmd(8'h81, 1, ad(7, 0), 16'hAAAA);
      cmd(8'h85, 2, ad(7, 2), 16'h9999);
      @(negedge clk);
      chk("R7 halt nrww", cpu_halt, 1); chk("R6 busy set", rww_busy, 1); chk("R9 irq armed", spm_irq, 0);
      wait_edges(WCYC - 1);
      @(negedge clk); chk("R7 halt last cycle", cpu_halt, 1);
      wait_edges(1);
      @(negedge clk);
      chk("R7 halt end", cpu_halt, 0); chk("R6 busy kept", rww_busy, 1); chk("R9 irq idle", spm_irq, 1);
      rd_chk(ad(7, 0), 16'h1234, "R3 second load ignored");
      rd_chk(ad(7, 1), 16'h5678, "R5 page write");
      rd_chk(ad(7, 2), 16'hFFFF, "R5 data ignored");
      rd_chk(ad(7, 3), 16'hFFFF, "R5 unloaded word");

      rd_chk(ad(1, 0), 16'h5A5A, "R8 blocked read");
      @(negedge clk); chk("R8 err set", rd_err, 1);

      csr_wr(8'h91);
      @(negedge clk); chk("R6 reenable", rww_busy, 0); chk("R9 irq", spm_irq, 1);
      rd_chk(ad(1, 0), 16'hFFFF, "R8 unblocked");
      @(negedge clk); chk("R8 sticky", rd_err, 1);

      cmd(8'h81, 1, ad(2, 3), 16'h0F0F);
      cmd(8'h85, 4, ad(2, 0), 16'h0000);
      @(negedge clk); chk("R7 no halt rww", cpu_halt, 0); chk("R2 fourth edge", rww_busy, 1);
      wait_edges(WCYC);
      @(negedge clk); chk("R6 busy after op", rww_busy, 1);
      csr_wr(8'h11);
      @(negedge clk); chk("R11 status", csr_rdata, 8'h00); chk("R9 irq off", spm_irq, 0);
      rd_chk(ad(2, 3), 16'h0F0F, "R5 rww write");

      cmd(8'h03, 5, ad(7, 0), 16'h0000);
      @(negedge clk); chk("R2 dropped busy", rww_busy, 0); chk("R2 dropped status", csr_rdata, 0);
      rd_chk(ad(7, 0), 16'h1234, "R2 not executed");

      cmd(8'h03, 3, ad(7, 3), 16'h1111);
      @(negedge clk); chk("R7 erase halt", cpu_halt, 1);
      wait_edges(ECYC);
      rd_chk(ad(7, 0), 16'hFFFF, "R4 erase w0");
      rd_chk(ad(7, 1), 16'hFFFF, "R4 erase w1");

      cmd(8'h05, 1, ad(6, 0), 16'h0000);
      csr_wr(8'h01);
      strobe(ad(6, 1), 16'h7777);
      wait_edges(WCYC);
      @(negedge clk); chk("R10 write during op", csr_rdata[0], 0);
      strobe(ad(6, 1), 16'h3333);
      csr_wr(8'h07);
      strobe(ad(6, 1), 16'h4444);
      cmd(8'h05, 1, ad(6, 0), 16'h0000);
      wait_edges(WCYC);
      rd_chk(ad(6, 1), 16'hFFFF, "R10 stray strobes ignored");

      cmd(8'h01, 1, ad(5, 0), 16'h1111);
      csr_wr(8'h11);
      cmd(8'h05, 1, ad(5, 0), 16'h0000);
      wait_edges(WCYC);
      csr_wr(8'h11);
      rd_chk(ad(5, 0), 16'hFFFF, "R6 reenable erases buffer");

      wait_edges(2);
      summary();
   end
endmodule